// File: doc/BRIEF.md
# Line Access Switch State Controller

This block is the digital control core of an eight-switch line access array on a subscriber line card. A three-bit command selects one switch arrangement: talk, one of the test monitor settings, the bridge setting, the drop test or all open. The block turns that command into eight registered switch enables. A latch-enable input lets several such blocks share one command bus. While it is low the command passes through. While it is high the last command taken in is held.

Safety paths take priority over the command. An under-voltage flag blocks the command and opens every switch. Once the supply is good again, the block stays open until latch-enable is seen low. A thermal-shutdown flag and an active-low force-off input open every switch without passing through the latch. Switching comes back by itself when either of them is released. An active-low thermal status output mirrors the thermal flag. Every asynchronous input passes through a two-flop synchronizer. A change between two closed arrangements always passes through one cycle with all switches open.

Top module: `lasw_ctrl`

## Requirements
- R1: During and after reset, with no command yet accepted, `sw_en` is 0x00 and `therm_n` is 1.
- R2: The command code is {`ctl_a`,`ctl_b`,`ctl_c`}, and `sw_en` bit k drives switch k+1. The steady-state mapping is:
  - 000 → 0x03 (talk)
  - 001 → 0x33 (test-in monitor)
  - 010 → 0x0F (test-out monitor)
  - 011 → 0x3C (test-in and test-out)
  - 100 → 0xF0 (test-in bridge)
  - 101 → 0x0C (drop test)
  - 110 and 111 → 0x00 (all open)
- R3: While `latch_en` is 0, a command change applied to the pins reaches `sw_en` on the third rising edge after it. A move from all-open to a closed set has no gap.
- R4: While `latch_en` is 1, changes on the command pins have no effect on `sw_en`.
- R5: While `uvlo` is 1, `sw_en` is 0x00 (the third edge after `uvlo` rises) and command changes are ignored.
- R6: When `uvlo` clears with `latch_en` high, `sw_en` stays 0x00 until `latch_en` goes low. When `uvlo` clears with `latch_en` already low, `sw_en` goes straight to the decoded command.
- R7: `force_off_n` low forces `sw_en` to 0x00 whatever `latch_en` and the held command are. When it returns high, the decoded command is restored with no re-arm.
- R8: `therm_sd` high forces `sw_en` to 0x00 on the third edge after it rises, and `therm_n` goes to 0 on the second edge. When the flag clears, `therm_n` returns to 1 and `sw_en` returns to the decoded command.
- R9: A change from one non-zero switch set to a different non-zero set shows 0x00 for exactly one cycle before the new set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_a | input | 1 | Command bit 2 (MSB) |
| ctl_b | input | 1 | Command bit 1 |
| ctl_c | input | 1 | Command bit 0 (LSB) |
| latch_en | input | 1 | 0 = command passes through, 1 = command held |
| uvlo | input | 1 | Supply under-voltage flag, active high |
| therm_sd | input | 1 | Thermal shutdown flag, active high |
| force_off_n | input | 1 | External force-all-open, active low |
| sw_en | output | 8 | Switch enables, bit k = switch k+1 |
| therm_n | output | 1 | Thermal status, 0 while in shutdown |

## Verification
All inputs reach the core through two synchronizer flops. The switch enables are registered one stage later, so every switch result is due on the third rising edge after the stimulus. The thermal status comes straight from the synchronizer and is due on the second edge. The bench drives on falling edges and samples on falling edges at exactly those counts. It checks the value one edge early where a latency is a requirement, and checks the one-cycle open gap of a break-before-make change on edges three and four. Steady-state checks wait six cycles so that any gap has passed.

// File: rtl/lasw_pkg.sv
package lasw_pkg;

  localparam int NUM_SW = 8;
  localparam int CODE_W = 3;

  typedef logic [NUM_SW-1:0] sw_vec_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [CODE_W-1:0] {
    OP_TALK    = 3'd0,
    OP_TIN     = 3'd1,
    OP_TOUT    = 3'd2,
    OP_TINOUT  = 3'd3,
    OP_BRIDGE  = 3'd4,
    OP_DROP    = 3'd5,
    OP_OFF6    = 3'd6,
    OP_OFF7    = 3'd7
  } op_e;

  localparam sw_vec_t SW_NONE = '0;

  // Switch groups: bit k of a vector drives switch k+1.
  localparam sw_vec_t GRP_BREAK  = sw_vec_t'(8'b0000_0011);
  localparam sw_vec_t GRP_TOUT   = sw_vec_t'(8'b0000_1100);
  localparam sw_vec_t GRP_TIN    = sw_vec_t'(8'b0011_0000);
  localparam sw_vec_t GRP_BRIDGE = sw_vec_t'(8'b1100_0000);

  function automatic sw_vec_t op_to_switches(input code_t code);
    sw_vec_t v;
    case (op_e'(code))
      OP_TALK:   v = GRP_BREAK;
      OP_TIN:    v = GRP_BREAK | GRP_TIN;
      OP_TOUT:   v = GRP_BREAK | GRP_TOUT;
      OP_TINOUT: v = GRP_TOUT  | GRP_TIN;
      OP_BRIDGE: v = GRP_TIN   | GRP_BRIDGE;
      OP_DROP:   v = GRP_TOUT;
      default:   v = SW_NONE;
    endcase
    return v;
  endfunction

  function automatic logic is_legal_set(input sw_vec_t v);
    return (v == SW_NONE) ||
           (v == GRP_BREAK) ||
           (v == (GRP_BREAK | GRP_TIN)) ||
           (v == (GRP_BREAK | GRP_TOUT)) ||
           (v == (GRP_TOUT | GRP_TIN)) ||
           (v == (GRP_TIN | GRP_BRIDGE)) ||
           (v == GRP_TOUT);
  endfunction

endpackage

// File: rtl/lasw_sync.sv
module lasw_sync #(
  parameter int          WIDTH  = 1,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lasw_hold.sv
module lasw_hold
  import lasw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  code_t   code_i,
  input  logic    hold_i,
  output code_t   eff_code_o,
  output sw_vec_t dec_sw_o
);

  code_t held_q;

  // Capture while open, freeze while hold is asserted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= code_t'(OP_OFF7);
    else if (!hold_i) held_q <= code_i;
  end

  // Transparent: while open the live code passes directly.
  assign eff_code_o = hold_i ? held_q : code_i;
  assign dec_sw_o   = op_to_switches(eff_code_o);

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(held_q)) else $error("held code changed while frozen"); // R4

endmodule

// File: rtl/lasw_seq.sv
module lasw_seq
  import lasw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    uvlo_i,
  input  logic    hold_i,
  input  logic    therm_i,
  input  logic    foff_n_i,
  input  sw_vec_t dec_sw_i,
  output sw_vec_t sw_o
);

  logic    armed_q;
  logic    arm_now;
  logic    force_open;
  logic    need_gap;
  sw_vec_t target_sw;
  sw_vec_t sw_q;

  // Interlock: cleared by lockout, set once the latch is seen open
  // while the supply is good.
  assign arm_now = !uvlo_i && (armed_q || !hold_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= arm_now;
  end

  // Thermal and external force-off bypass the latch entirely.
  assign force_open = !arm_now || therm_i || !foff_n_i;
  assign target_sw  = force_open ? SW_NONE : dec_sw_i;

  // Break-before-make between two different closed sets.
  assign need_gap = (sw_q != SW_NONE) && (target_sw != SW_NONE) &&
                    (target_sw != sw_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sw_q <= SW_NONE;
    else if (need_gap) sw_q <= SW_NONE;
    else               sw_q <= target_sw;
  end

  assign sw_o = sw_q;

  AST_UVLO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (sw_q == SW_NONE)) else $error("switch closed in lockout"); // R5
  AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && hold_i) |=> (sw_q == SW_NONE)) else $error("left lockout without open latch"); // R6
  AST_FORCE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !foff_n_i |=> (sw_q == SW_NONE)) else $error("switch closed under force-off"); // R7
  AST_THERM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    therm_i |=> (sw_q == SW_NONE)) else $error("switch closed in thermal shutdown"); // R8
  AST_BREAK_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q != SW_NONE) |=> ((sw_q == $past(sw_q)) || (sw_q == SW_NONE)))
    else $error("direct jump between closed sets"); // R9
  AST_LEGAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    is_legal_set(sw_q)) else $error("illegal switch combination"); // R2

endmodule

// File: rtl/lasw_ctrl.sv
module lasw_ctrl
  import lasw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_a,
  input  logic       ctl_b,
  input  logic       ctl_c,
  input  logic       latch_en,
  input  logic       uvlo,
  input  logic       therm_sd,
  input  logic       force_off_n,
  output logic [7:0] sw_en,
  output logic       therm_n
);

  // Bundle layout: [6:4] code, [3] hold, [2] uvlo, [1] thermal, [0] force_off_n
  localparam int BUS_W = CODE_W + 4;
  localparam logic [BUS_W-1:0] BUS_RST = {CODE_W'(0), 1'b1, 1'b1, 1'b0, 1'b1};

  logic [BUS_W-1:0] raw_bus;
  logic [BUS_W-1:0] syn_bus;
  code_t   code_s;
  logic    hold_s;
  logic    uvlo_s;
  logic    therm_s;
  logic    foff_n_s;
  code_t   eff_code;
  sw_vec_t dec_sw;
  sw_vec_t sw_vec;

  assign raw_bus = {ctl_a, ctl_b, ctl_c, latch_en, uvlo, therm_sd, force_off_n};

  lasw_sync #(
    .WIDTH   (BUS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (BUS_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_bus),
    .q_o   (syn_bus)
  );

  assign code_s   = syn_bus[BUS_W-1 -: CODE_W];
  assign hold_s   = syn_bus[3];
  assign uvlo_s   = syn_bus[2];
  assign therm_s  = syn_bus[1];
  assign foff_n_s = syn_bus[0];

  lasw_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_i     (code_s),
    .hold_i     (hold_s),
    .eff_code_o (eff_code),
    .dec_sw_o   (dec_sw)
  );

  lasw_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .uvlo_i   (uvlo_s),
    .hold_i   (hold_s),
    .therm_i  (therm_s),
    .foff_n_i (foff_n_s),
    .dec_sw_i (dec_sw),
    .sw_o     (sw_vec)
  );

  assign sw_en   = sw_vec;
  assign therm_n = !therm_s;

  AST_THERM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(therm_s) |=> (sw_en == '0)) else $error("thermal entry did not open switches"); // R8

endmodule

// File: tb/lasw_ctrl_tb.sv
`timescale 1ns/1ps
module lasw_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = 3'b000;
  logic       latch_en = 1'b1;
  logic       uvlo = 1'b1;
  logic       therm_sd = 1'b0;
  logic       force_off_n = 1'b1;
  logic [7:0] sw_en;
  logic       therm_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lasw_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_a       (cmd[2]),
    .ctl_b       (cmd[1]),
    .ctl_c       (cmd[0]),
    .latch_en    (latch_en),
    .uvlo        (uvlo),
    .therm_sd    (therm_sd),
    .force_off_n (force_off_n),
    .sw_en       (sw_en),
    .therm_n     (therm_n)
  );

  function automatic logic [7:0] expect_sw(input logic [2:0] c);
    case (c)
      3'd0: return 8'h03;
      3'd1: return 8'h33;
      3'd2: return 8'h0F;
      3'd3: return 8'h3C;
      3'd4: return 8'hF0;
      3'd5: return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    tick(3);
    check("R1 sw in reset", sw_en, 8'h00);
    check("R1 therm_n in reset", {7'd0, therm_n}, 8'h01);
    rst_n = 1'b1;
    tick(6);
    check("R1 sw after reset", sw_en, 8'h00);
  endtask

  task automatic t_powerup_latched;
    uvlo = 1'b0;
    tick(8);
    check("R6 supply ok latch high stays open", sw_en, 8'h00);
    cmd = 3'd0;
    latch_en = 1'b0;
    tick(2);
    check("R3 not yet at edge 2", sw_en, 8'h00);
    tick(1);
    check("R3 talk at edge 3 no gap", sw_en, 8'h03);
  endtask

  task automatic t_decode;
    for (int c = 0; c < 8; c++) begin
      cmd = 3'(c);
      tick(6);
      check($sformatf("R2 code %0d", c), sw_en, expect_sw(3'(c)));
    end
  endtask

  task automatic t_bbm;
    cmd = 3'd0;
    tick(6);
    cmd = 3'd1;
    tick(3);
    check("R9 gap cycle open", sw_en, 8'h00);
    tick(1);
    check("R9 new set after gap", sw_en, 8'h33);
    cmd = 3'd3;
    tick(3);
    check("R9 gap cycle open 2", sw_en, 8'h00);
    tick(1);
    check("R9 new set after gap 2", sw_en, 8'h3C);
  endtask

  task automatic t_latch;
    cmd = 3'd0;
    tick(6);
    latch_en = 1'b1;
    tick(1);
    cmd = 3'd4;
    tick(6);
    check("R4 held while latch high", sw_en, 8'h03);
    cmd = 3'd2;
    tick(6);
    check("R4 still held", sw_en, 8'h03);
    latch_en = 1'b0;
    tick(6);
    check("R3 passes when latch low", sw_en, 8'h0F);
  endtask

  task automatic t_uvlo;
    cmd = 3'd1;
    tick(6);
    uvlo = 1'b1;
    tick(2);
    check("R5 before edge 3", sw_en, 8'h33);
    tick(1);
    check("R5 open at edge 3", sw_en, 8'h00);
    cmd = 3'd2;
    tick(6);
    check("R5 commands blocked", sw_en, 8'h00);
    latch_en = 1'b1;
    uvlo = 1'b0;
    tick(8);
    check("R6 recovered latch high stays open", sw_en, 8'h00);
    latch_en = 1'b0;
    tick(6);
    check("R6 latch low releases", sw_en, 8'h0F);
    uvlo = 1'b1;
    tick(6);
    check("R5 second lockout", sw_en, 8'h00);
    uvlo = 1'b0;
    tick(3);
    check("R6 direct when latch already low", sw_en, 8'h0F);
  endtask

  task automatic t_force;
    latch_en = 1'b1;
    tick(4);
    force_off_n = 1'b0;
    tick(3);
    check("R7 force-off with latch high", sw_en, 8'h00);
    force_off_n = 1'b1;
    tick(3);
    check("R7 restore after release", sw_en, 8'h0F);
    latch_en = 1'b0;
    tick(4);
  endtask

  task automatic t_thermal;
    therm_sd = 1'b1;
    tick(2);
    check("R8 therm_n low at edge 2", {7'd0, therm_n}, 8'h00);
    check("R8 sw still closed at edge 2", sw_en, 8'h0F);
    tick(1);
    check("R8 sw open at edge 3", sw_en, 8'h00);
    therm_sd = 1'b0;
    tick(2);
    check("R8 therm_n back high", {7'd0, therm_n}, 8'h01);
    tick(1);
    check("R8 auto return", sw_en, 8'h0F);
  endtask

  initial begin
    t_reset();
    t_powerup_latched();
    t_decode();
    t_bbm();
    t_latch();
    t_uvlo();
    t_force();
    t_thermal();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule